// File: doc/BRIEF.md
# Sample Buffer Host Access Controller

This block lets a host bus reach a word-wide sample buffer (4096 words of 12 bits by default) and a calibration register of the same width. The host issues one command per strobe cycle: a 5-bit function code plus a data word. The decoded commands read the buffer word under the pointer, write a word there for memory testing, preload the pointer, or load the calibration register. A read or a write advances the pointer by one and wraps it at the top of the buffer, so a block transfer needs only repeated strobes.

The conversion sequencer owns the buffer while digitisation runs. During that time it stores samples through its own write port, and every host strobe is refused without a response. When the sequencer signals the end of conversion, the pointer returns to zero so the host can read the whole record from the first word.

All results are registered. Acknowledge, read data and the calibration value change on the clock edge that samples the strobe.

Top module: `bufmem_access_ctrl`

## Requirements
- R1: After reset the acknowledge and the read data are 0, the calibration value is 0 and the pointer is 0.
- R2: An accepted strobe with function code 0 returns the buffer word at the pointer on `rdata` one cycle later, raises `ack` for that cycle and advances the pointer by one.
- R3: An accepted strobe with function code 16 stores `wdata` at the pointer, raises `ack` one cycle later and advances the pointer by one.
- R4: An accepted strobe with function code 17 loads the pointer with the low ADDR_W bits of `wdata`, raises `ack` and leaves the buffer unchanged.
- R5: An accepted strobe with function code 18 loads the calibration register from `wdata`, raises `ack` one cycle later and leaves the pointer unchanged.
- R6: A pointer step from the last word (2^ADDR_W - 1) goes to word 0.
- R7: While `seq_busy` is high a host strobe is refused. `ack` stays low and the pointer, buffer, calibration value and `rdata` keep their values.
- R8: A `seq_done` pulse clears the pointer to 0. A host strobe in that same cycle is refused.
- R9: A strobe with any function code other than 0, 16, 17 or 18 gives no `ack` and changes no pointer, buffer word, calibration value or read data.
- R10: A sequencer write (`seq_we`) stores `seq_wdata` at `seq_addr` only while `seq_busy` is high. At other times it has no effect.
- R11: `ack` is high for exactly one cycle after each accepted strobe and low in every cycle that follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcode | input | 5 | Host function code |
| strobe | input | 1 | Host command strobe, one cycle per command |
| wdata | input | DATA_W | Host write / preload / calibration data |
| seq_busy | input | 1 | Conversion sequencer owns the buffer |
| seq_done | input | 1 | End-of-conversion pulse |
| seq_we | input | 1 | Sequencer sample write enable |
| seq_addr | input | ADDR_W | Sequencer sample address |
| seq_wdata | input | DATA_W | Sequencer sample data |
| rdata | output | DATA_W | Last word read by the host |
| ack | output | 1 | Response flag for an accepted command |
| cal_value | output | DATA_W | Calibration / bias register value |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 12. With only 16 words, one fill pass covers the whole buffer, and both the pointer wrap and a preload to the last word come up often under random commands. The 12-bit width keeps the full calibration and sample range. Random commands mix decoded and undecoded codes with refusals for busy, and a bench model tracks the pointer and buffer contents. Directed sequences cover a busy phase with sequencer writes and an end-of-conversion pulse that arrives together with a host strobe.

// File: rtl/bufmem_access_pkg.sv
package bufmem_access_pkg;

  localparam int FC_W = 5;

  localparam logic [FC_W-1:0] FC_READ  = 5'd0;
  localparam logic [FC_W-1:0] FC_WRITE = 5'd16;
  localparam logic [FC_W-1:0] FC_LOAD  = 5'd17;
  localparam logic [FC_W-1:0] FC_CAL   = 5'd18;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_LOAD  = 3'd3,
    CMD_CAL   = 3'd4
  } host_cmd_e;

  // Maps a function code to a command; unknown codes map to CMD_NONE.
  function automatic host_cmd_e fc_to_cmd(input logic [FC_W-1:0] fc);
    host_cmd_e c;
    case (fc)
      FC_READ:  c = CMD_READ;
      FC_WRITE: c = CMD_WRITE;
      FC_LOAD:  c = CMD_LOAD;
      FC_CAL:   c = CMD_CAL;
      default:  c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import bufmem_access_pkg::*;
(
  input  logic            strobe,
  input  logic [FC_W-1:0] fcode,
  input  logic            seq_busy,
  input  logic            seq_done,
  output host_cmd_e       cmd,
  output logic            refused,
  output logic            stray
);
  host_cmd_e raw_cmd;

  always_comb begin
    raw_cmd = fc_to_cmd(fcode);
    refused = strobe && (seq_busy || seq_done);
    stray   = strobe && !refused && (raw_cmd == CMD_NONE);
    if (strobe && !refused) cmd = raw_cmd;
    else                    cmd = CMD_NONE;
  end
endmodule

// File: rtl/acc_addr_ptr.sv
module acc_addr_ptr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrap
);
  localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

  // Successor of a pointer value, returning to zero after the last word.
  function automatic logic [ADDR_W-1:0] next_ptr(input logic [ADDR_W-1:0] p);
    if (p == PTR_MAX) return '0;
    return p + 1'b1;
  endfunction

  assign wrap = step && !clr && !load && (ptr == PTR_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (clr)  ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= next_ptr(ptr);
  end
endmodule

// File: rtl/acc_buffer.sv
module acc_buffer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              seq_we,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [DATA_W-1:0] seq_wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  // Host and sequencer never write together: the decoder refuses host
  // strobes while the sequencer is busy, so the sequencer takes the port.
  always_comb begin
    wr_en   = host_we || seq_we;
    wr_addr = seq_we ? seq_addr  : host_addr;
    wr_data = seq_we ? seq_wdata : host_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[host_addr];
  end
endmodule

// File: rtl/bufmem_access_ctrl.sv
module bufmem_access_ctrl
  import bufmem_access_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        fcode,
  input  logic              strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              seq_we,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [DATA_W-1:0] seq_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  output logic [DATA_W-1:0] cal_value
);
  host_cmd_e         cmd;
  logic              refused;
  logic              stray;
  logic              host_rd, host_wr, host_ld, host_cal;
  logic              seq_wr_ok;
  logic [ADDR_W-1:0] ptr_q;
  logic              ptr_wrap;
  logic              ack_q;
  logic [DATA_W-1:0] cal_q;

  acc_decode u_dec (
    .strobe   (strobe),
    .fcode    (fcode),
    .seq_busy (seq_busy),
    .seq_done (seq_done),
    .cmd      (cmd),
    .refused  (refused),
    .stray    (stray)
  );

  assign host_rd   = (cmd == CMD_READ);
  assign host_wr   = (cmd == CMD_WRITE);
  assign host_ld   = (cmd == CMD_LOAD);
  assign host_cal  = (cmd == CMD_CAL);
  assign seq_wr_ok = seq_we && seq_busy;

  acc_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (seq_done),
    .load     (host_ld),
    .load_val (wdata[ADDR_W-1:0]),
    .step     (host_rd || host_wr),
    .ptr      (ptr_q),
    .wrap     (ptr_wrap)
  );

  acc_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_wr),
    .host_addr  (ptr_q),
    .host_wdata (wdata),
    .seq_we     (seq_wr_ok),
    .seq_addr   (seq_addr),
    .seq_wdata  (seq_wdata),
    .rd_en      (host_rd),
    .rd_data    (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      cal_q <= '0;
    end else begin
      ack_q <= (cmd != CMD_NONE);
      if (host_cal) cal_q <= wdata;
    end
  end

  assign ack       = ack_q;
  assign cal_value = cal_q;
endmodule

// File: rtl/bufmem_access_chk.sv
module bufmem_access_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        fcode,
  input logic              strobe,
  input logic [DATA_W-1:0] wdata,
  input logic              seq_busy,
  input logic              seq_done,
  input logic              ack,
  input logic [DATA_W-1:0] cal_value,
  input logic [DATA_W-1:0] rdata,
  input logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic accept, known, stepping;
  assign accept   = strobe && !seq_busy && !seq_done;
  assign known    = (fcode == 5'd0) || (fcode == 5'd16) || (fcode == 5'd17) || (fcode == 5'd18);
  assign stepping = accept && ((fcode == 5'd0) || (fcode == 5'd16));

  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> (!ack && $stable(cal_value) && $stable(rdata)));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !ack);

  // R5
  cal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fcode == 5'd18) |=> (ack && cal_value == $past(wdata)));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (ptr == '0 && !ack));

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && ptr == LAST) |=> (ptr == '0));

  // R9
  stray_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !known) |=> (!ack && $stable(ptr) && $stable(cal_value) && $stable(rdata)));
endmodule

bind bufmem_access_ctrl bufmem_access_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fcode     (fcode),
  .strobe    (strobe),
  .wdata     (wdata),
  .seq_busy  (seq_busy),
  .seq_done  (seq_done),
  .ack       (ack),
  .cal_value (cal_value),
  .rdata     (rdata),
  .ptr       (ptr_q)
);

// File: tb/tb_bufmem_access_ctrl.sv
module tb_bufmem_access_ctrl;
  localparam int AW = 4;
  localparam int DW = 12;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    fcode = '0;
  logic          strobe = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          seq_busy = 1'b0;
  logic          seq_done = 1'b0;
  logic          seq_we = 1'b0;
  logic [AW-1:0] seq_addr = '0;
  logic [DW-1:0] seq_wdata = '0;
  logic [DW-1:0] rdata;
  logic          ack;
  logic [DW-1:0] cal_value;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] m_mem [WORDS];
  logic [AW-1:0] m_ptr = '0;
  logic [DW-1:0] m_rdata = '0;
  logic [DW-1:0] m_cal = '0;

  always #10 clk = ~clk;

  bufmem_access_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .fcode(fcode), .strobe(strobe), .wdata(wdata),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_we(seq_we),
    .seq_addr(seq_addr), .seq_wdata(seq_wdata),
    .rdata(rdata), .ack(ack), .cal_value(cal_value)
  );

  function automatic bit is_known(input logic [4:0] fc);
    return (fc == 5'd0) || (fc == 5'd16) || (fc == 5'd17) || (fc == 5'd18);
  endfunction

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(WORDS - 1)) ? '0 : AW'(p + 1);
  endfunction

  function automatic string req_of(input logic [4:0] fc, input bit busy, input bit done);
    if (done) return "R8";
    if (busy) return "R7";
    case (fc)
      5'd0:    return "R2";
      5'd16:   return "R3";
      5'd17:   return "R4";
      5'd18:   return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One host command; results checked on the following negedge.
  task automatic host_op(input logic [4:0] fc, input logic [DW-1:0] d, input bit busy, input bit done);
    string r;
    bit    acc;
    r   = req_of(fc, busy, done);
    acc = !busy && !done;
    @(negedge clk);
    fcode = fc; wdata = d; strobe = 1'b1; seq_busy = busy; seq_done = done;
    @(posedge clk);
    @(negedge clk);
    strobe = 1'b0; seq_busy = 1'b0; seq_done = 1'b0;
    if (done) m_ptr = '0;
    if (acc) begin
      case (fc)
        5'd0:  begin m_rdata = m_mem[m_ptr]; m_ptr = bump(m_ptr); end
        5'd16: begin m_mem[m_ptr] = d; m_ptr = bump(m_ptr); end
        5'd17: m_ptr = d[AW-1:0];
        5'd18: m_cal = d;
        default: ;
      endcase
    end
    chk(r, "ack", {31'd0, ack}, {31'd0, acc && is_known(fc)});
    chk(r, "rdata", {20'd0, rdata}, {20'd0, m_rdata});
    chk(r, "cal_value", {20'd0, cal_value}, {20'd0, m_cal});
    @(negedge clk);
    // R11: no strobe in the previous cycle, so no acknowledge
    chk("R11", "idle ack", {31'd0, ack}, 32'd0);
  endtask

  task automatic seq_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit busy);
    @(negedge clk);
    seq_we = 1'b1; seq_addr = a; seq_wdata = d; seq_busy = busy;
    @(posedge clk);
    @(negedge clk);
    seq_we = 1'b0; seq_busy = 1'b0;
    if (busy) m_mem[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "reset ack", {31'd0, ack}, 32'd0);
    chk("R1", "reset rdata", {20'd0, rdata}, 32'd0);
    chk("R1", "reset cal", {20'd0, cal_value}, 32'd0);

    // R3 fill starting from the reset pointer (R1: pointer at 0)
    for (int i = 0; i < WORDS; i++) host_op(5'd16, DW'(12'h100 + i * 37), 1'b0, 1'b0);
    // R2 and R6: reading through the wrap
    for (int i = 0; i <= WORDS; i++) host_op(5'd0, '0, 1'b0, 1'b0);
    // R4 preload to the last word, then R6 wrap on read
    host_op(5'd17, 12'hF0F, 1'b0, 1'b0);
    host_op(5'd0, '0, 1'b0, 1'b0);
    host_op(5'd0, '0, 1'b0, 1'b0);
    // R5
    host_op(5'd18, 12'hABC, 1'b0, 1'b0);
    host_op(5'd0, '0, 1'b0, 1'b0);
    // R9: undecoded codes, then a read shows the pointer did not move
    host_op(5'd1, 12'h555, 1'b0, 1'b0);
    host_op(5'd31, 12'h00F, 1'b0, 1'b0);
    host_op(5'd19, 12'h777, 1'b0, 1'b0);
    host_op(5'd0, '0, 1'b0, 1'b0);
    // R7: refused write, calibration and preload while busy
    host_op(5'd16, 12'h999, 1'b1, 1'b0);
    host_op(5'd18, 12'h321, 1'b1, 1'b0);
    host_op(5'd17, 12'h003, 1'b1, 1'b0);
    host_op(5'd0, '0, 1'b0, 1'b0);
    // R10: sequencer writes land only while busy
    host_op(5'd17, 12'h007, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) seq_write(AW'(i), DW'(12'h800 + i), 1'b1);
    seq_write(AW'(6), 12'h0EE, 1'b0);
    // R8: end of conversion with a simultaneous strobe
    host_op(5'd16, 12'h444, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) host_op(5'd0, '0, 1'b0, 1'b0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [4:0] fc;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1, 2: fc = 5'd0;
        3, 4:    fc = 5'd16;
        5:       fc = 5'd17;
        6:       fc = 5'd18;
        default: fc = 5'($urandom_range(0, 31));
      endcase
      if ($urandom_range(0, 19) == 0)
        seq_write(AW'($urandom_range(0, WORDS - 1)), DW'($urandom), 1'($urandom_range(0, 1)));
      host_op(fc, DW'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 15) == 0));
    end
    report();
  end
endmodule